// File: doc/BRIEF.md
# Exception Restart-Address Capture

This block sits at the commit point of a pipelined processor whose branches carry one delay slot. When the committing instruction signals an exception, the block stores a restart address in an exception-PC register. It also stores a cause word that holds the exception code and a flag showing whether the fault came from a delay slot. Fetch is then redirected to a fixed handler vector.

If the faulting instruction sits in a delay slot, restarting at that instruction would lose the branch it belongs to. In that case the stored address is that of the branch, which is one instruction width below the faulting address, and the delay-slot flag is set. The handler uses this flag to know it must re-run or emulate the branch. Apart from these two values, nothing about the branch outcome is kept.

A small controller has two states. In `ST_RUN` it accepts a strobe. The transition *take* leads to `ST_REDIRECT`, which lasts one cycle, drives the fetch redirect and flushes younger instructions. The transition *resume* leads back to `ST_RUN`.

Top module: `exc_capture_unit`

## Requirements
- R1: After reset, `epc_o` and `cause_o` are zero, `redirect_o` is low, and the controller is in `ST_RUN`.
- R2: An exception accepted outside a delay slot loads `epc_o` with the committing PC and clears bit 31 of `cause_o`.
- R3: An exception accepted in a delay slot loads `epc_o` with the committing PC minus 4 and sets bit 31 of `cause_o`.
- R4: The 5-bit exception code is stored in `cause_o[6:2]`. All other bits of `cause_o` except bit 31 read zero. A breakpoint, code 9, therefore reads as `cause_o[6:2] == 9`.
- R5: `redirect_o` is high for exactly the one cycle after the strobe edge, with `redirect_pc_o` equal to the vector. `epc_o` and `cause_o` show their new values in that same cycle.
- R6: A strobe arriving while `redirect_o` is high belongs to a flushed instruction and is ignored. `epc_o` and `cause_o` keep the values of the accepted exception.
- R7: Without an accepted strobe, `epc_o` and `cause_o` hold their values.
- R8: An external interrupt, code 0, taken while a delay slot commits follows the same branch-address rule as R3.
- R9: The delay-slot subtraction wraps modulo 2^32, so a slot PC of 0 gives `epc_o == 32'hFFFF_FFFC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid_i | input | 1 | Committing instruction raises an exception |
| exc_pc_i | input | 32 | Address of the committing instruction |
| exc_in_slot_i | input | 1 | Committing instruction is in a branch delay slot |
| exc_code_i | input | 5 | Exception code |
| epc_o | output | 32 | Captured restart address |
| cause_o | output | 32 | Cause word: bit 31 delay-slot flag, bits 6:2 code |
| redirect_o | output | 1 | Fetch redirect and flush of younger instructions |
| redirect_pc_o | output | 32 | Handler vector address |

## Verification
A wrong slot decision appears in `epc_o` as an address exactly 4 away from the expected one, with bit 31 of `cause_o` flipped. It is visible in the cycle when `redirect_o` is high. If the controller gets stuck in `ST_REDIRECT` or falls back too early, the redirect pulse is one cycle too long or missing. A flushed strobe that is wrongly accepted overwrites `epc_o` one cycle after the redirect. The scoreboard compares the captured values on every redirect pulse, and the drivers check the edges of the pulse directly.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [0:0] {
        ST_RUN      = 1'b0,
        ST_REDIRECT = 1'b1
    } exc_state_e;

endpackage

// File: rtl/exc_restart_sel.sv
module exc_restart_sel #(
    parameter int PC_W        = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic            in_slot_i,
    output logic [PC_W-1:0] restart_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

    // In a delay slot the restart point is the owning branch one slot back.
    always_comb begin
        if (in_slot_i) restart_o = pc_i - STEP;
        else           restart_o = pc_i;
    end
endmodule

// File: rtl/exc_cause_fmt.sv
module exc_cause_fmt #(
    parameter int CAUSE_W  = 32,
    parameter int CODE_W   = 5,
    parameter int CODE_LSB = 2
) (
    input  logic [CODE_W-1:0]  code_i,
    input  logic               in_slot_i,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

    genvar b;
    generate
        for (b = 0; b < CAUSE_W; b++) begin : g_bit
            if (b == CAUSE_W - 1) begin : g_bd
                assign cause_o[b] = in_slot_i;
            end else if (b >= CODE_LSB && b <= CODE_MSB) begin : g_code
                assign cause_o[b] = code_i[b - CODE_LSB];
            end else begin : g_zero
                assign cause_o[b] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/exc_ctrl_fsm.sv
module exc_ctrl_fsm
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exc_valid_i,
    output logic accept_o,
    output logic redirect_o
);
    exc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        accept_o   = 1'b0;
        redirect_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (exc_valid_i) begin
                    accept_o = 1'b1;
                    state_d  = ST_REDIRECT;   // take
                end
            end
            ST_REDIRECT: begin
                redirect_o = 1'b1;            // flush cycle: strobes dropped
                state_d    = ST_RUN;          // resume
            end
            default: state_d = ST_RUN;
        endcase
    end

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);
    a_r5_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> redirect_o);
    a_r6_no_accept_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> !accept_o);
endmodule

// File: rtl/exc_capture_unit.sv
module exc_capture_unit #(
    parameter int              PC_W        = 32,
    parameter int              CODE_W      = 5,
    parameter int              CAUSE_W     = 32,
    parameter int              CODE_LSB    = 2,
    parameter int              INSTR_BYTES = 4,
    parameter logic [PC_W-1:0] VECTOR      = 32'h8000_0180
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_valid_i,
    input  logic [PC_W-1:0]    exc_pc_i,
    input  logic               exc_in_slot_i,
    input  logic [CODE_W-1:0]  exc_code_i,
    output logic [PC_W-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               redirect_o,
    output logic [PC_W-1:0]    redirect_pc_o
);
    logic               accept;
    logic [PC_W-1:0]    restart;
    logic [CAUSE_W-1:0] cause_word;
    logic [PC_W-1:0]    epc_q;
    logic [CAUSE_W-1:0] cause_q;

    exc_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_valid_i(exc_valid_i),
        .accept_o   (accept),
        .redirect_o (redirect_o)
    );

    exc_restart_sel #(.PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)) u_sel (
        .pc_i     (exc_pc_i),
        .in_slot_i(exc_in_slot_i),
        .restart_o(restart)
    );

    exc_cause_fmt #(.CAUSE_W(CAUSE_W), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB)) u_fmt (
        .code_i   (exc_code_i),
        .in_slot_i(exc_in_slot_i),
        .cause_o  (cause_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (accept) begin
            epc_q   <= restart;
            cause_q <= cause_word;
        end
    end

    assign epc_o         = epc_q;
    assign cause_o       = cause_q;
    assign redirect_pc_o = VECTOR;

    a_r3_slot_backs_up: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && exc_in_slot_i) |=> (epc_o == $past(exc_pc_i) - PC_W'(INSTR_BYTES)) && cause_o[CAUSE_W-1]);
    a_r2_plain_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !exc_in_slot_i) |=> (epc_o == $past(exc_pc_i)) && !cause_o[CAUSE_W-1]);
    a_r4_code_field: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> cause_o[CODE_LSB +: CODE_W] == $past(exc_code_i));
    a_r6_flush_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> $stable(epc_o) && $stable(cause_o));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid_i |=> $stable(epc_o) && $stable(cause_o));
endmodule

// File: tb/test_exc_capture_unit.sv
module test_exc_capture_unit;
    localparam logic [31:0] VEC = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid_i = 1'b0;
    logic [31:0] exc_pc_i = '0;
    logic        exc_in_slot_i = 1'b0;
    logic [4:0]  exc_code_i = '0;
    logic [31:0] epc_o, cause_o, redirect_pc_o;
    logic        redirect_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct { logic [31:0] epc; logic [31:0] cause; string req; } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    exc_capture_unit i_exc_capture_unit (
        .clk(clk), .rst_n(rst_n), .exc_valid_i(exc_valid_i), .exc_pc_i(exc_pc_i),
        .exc_in_slot_i(exc_in_slot_i), .exc_code_i(exc_code_i), .epc_o(epc_o),
        .cause_o(cause_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cause(logic slot, logic [4:0] code);
        return {slot, 24'd0, code, 2'b00};
    endfunction

    // Driver: one-cycle strobe, expected capture pushed to the scoreboard.
    task automatic raise(string req, logic [31:0] pc, logic slot, logic [4:0] code);
        exp_t e;
        @(negedge clk);
        exc_valid_i = 1'b1; exc_pc_i = pc; exc_in_slot_i = slot; exc_code_i = code;
        e.epc = slot ? pc - 32'd4 : pc;
        e.cause = mk_cause(slot, code);
        e.req = req;
        sb.push_back(e);
        @(negedge clk);
        check("R5 pulse high", {31'd0, redirect_o}, 32'd1);
        exc_valid_i = 1'b0;
        @(negedge clk);
        check("R5 pulse ends", {31'd0, redirect_o}, 32'd0);
    endtask

    // Monitor: compare captured values on each redirect cycle.
    always @(negedge clk) begin
        if (rst_n && redirect_o) begin
            if (sb.size() == 0) begin
                check("R6 unexpected redirect", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " epc"}, epc_o, e.epc);
                check({e.req, " cause"}, cause_o, e.cause);
                check("R5 vector", redirect_pc_o, VEC);
            end
        end
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 epc", epc_o, 32'd0);
        check("R1 cause", cause_o, 32'd0);
        check("R1 redirect", {31'd0, redirect_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", {31'd0, redirect_o}, 32'd0);

        raise("R2", 32'h0000_1000, 1'b0, 5'd4);
        raise("R3", 32'h0000_2004, 1'b1, 5'd12);
        raise("R4 breakpoint", 32'h0040_0100, 1'b0, 5'd9);
        raise("R4 breakpoint in slot", 32'h0040_0208, 1'b1, 5'd9);
        raise("R8 interrupt in slot", 32'h0000_3010, 1'b1, 5'd0);
        raise("R9 wrap", 32'h0000_0000, 1'b1, 5'd31);
        raise("R2 max code", 32'hFFFF_FFFC, 1'b0, 5'd31);

        // R6: strobe held into the flush cycle must be dropped.
        @(negedge clk);
        exc_valid_i = 1'b1; exc_pc_i = 32'h0000_5000; exc_in_slot_i = 1'b0; exc_code_i = 5'd7;
        begin
            exp_t e;
            e.epc = 32'h0000_5000; e.cause = mk_cause(1'b0, 5'd7); e.req = "R6 first";
            sb.push_back(e);
        end
        @(negedge clk);
        exc_pc_i = 32'h0000_6008; exc_in_slot_i = 1'b1; exc_code_i = 5'd3;
        @(negedge clk);
        exc_valid_i = 1'b0;
        check("R6 epc kept", epc_o, 32'h0000_5000);
        check("R6 cause kept", cause_o, mk_cause(1'b0, 5'd7));
        check("R6 no second pulse", {31'd0, redirect_o}, 32'd0);

        // R7: idle cycles leave the registers untouched.
        exc_pc_i = 32'hDEAD_BEEC; exc_in_slot_i = 1'b1; exc_code_i = 5'd1;
        repeat (4) @(negedge clk);
        check("R7 epc hold", epc_o, 32'h0000_5000);
        check("R7 cause hold", cause_o, mk_cause(1'b0, 5'd7));

        check("scoreboard drained", sb.size(), 32'd0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule